// File: doc/BRIEF.md
# Input Change-Detection Interrupt Controller

This block samples a bank of 8-bit digital input ports, finds transitions on them, and signals the host through one level interrupt line. Each port carries two 8-bit enable masks, one for upward and one for downward transitions. A control byte sits above all ports. It holds a master enable for edge detection, a separate enable for each direction, an overflow-detect enable and an interrupt-output enable.

Detected events latch into sticky flags. The host reads these flags from a status byte and acknowledges them by writing ones to a clear byte. When a new qualifying edge arrives while an earlier event is still unacknowledged, an overflow flag records that an event was merged. The host reaches every register through a plain byte-wide bus with a single-cycle write strobe and a combinational read port. Input pins cross into the clock domain through a two-flop synchroniser.

Top module: `chg_irq_top`

## Requirements
- R1: After reset the control byte, the status byte, every port mask and the `irq` pin are all zero.
- R2: For port p, the upward mask is at address 0x40 + 16·p + 2 and the downward mask at 0x40 + 16·p + 3. Both are read/write. Writing one port's mask leaves every other port's masks unchanged.
- R3: Control byte (address 0x03) bits: 0 master edge enable, 1 overflow-detect enable, 2 interrupt enable, 3 upward-direction enable, 4 downward-direction enable. A 0→1 change on an input whose upward mask bit is set, with control bits 0 and 3 set, sets status bit 0 and status bit 3 at the third rising clock edge after the pin changes, and not before.
- R4: A 1→0 change on an input whose downward mask bit is set, with control bits 0 and 4 set, sets status bits 0 and 4 (status is at address 0x02).
- R5: A transition produces no event when the channel's mask bit for that direction is clear, or when the control bit for that direction is clear.
- R6: When control bit 0 is clear, no transition sets any status flag.
- R7: A qualifying edge that arrives while status bit 0 is already set sets status bit 1 (overflow) only when control bit 1 is set.
- R8: Writing the clear byte (address 0x01) with bit 3 set clears status bits 0, 3 and 4. Writing it with bit 2 set clears status bit 1. Bits written as zero leave their flags unchanged. Status flags otherwise stay set.
- R9: `irq` is high exactly while control bit 2 is set and status bit 0 or status bit 1 is set. Status bit 2 shows the current `irq` level.
- R10: After control is written with zero, `irq` is low from the next cycle and later transitions set no flags. Flags that were already pending are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| din | input | 8·NUM_PORTS | Asynchronous digital inputs, port p on bits 8p+7..8p |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with NUM_PORTS = 3 and the default 8-bit address. The top port therefore decodes at 0x60, so the stride arithmetic is exercised beyond port 0. One downward edge is taken on a channel of port 2, which shows that the hit reduction across ports includes ports other than the first. Several mask patterns are used that differ between directions and between ports. With these, a channel can be enabled for one direction and masked for the other, which gives the R5 cases, and a second edge can be placed on a different channel of the same port while an event is pending, which gives the overflow sequence of R7.

// File: rtl/chg_irq_pkg.sv
`timescale 1ns/1ps
package chg_irq_pkg;
  localparam int unsigned OFS_CLEAR    = 1;
  localparam int unsigned OFS_STATUS   = 2;
  localparam int unsigned OFS_CTRL     = 3;
  localparam int unsigned PORT_BASE    = 'h40;
  localparam int unsigned PORT_STRIDE  = 16;
  localparam int unsigned PORT_UP_OFS  = 2;
  localparam int unsigned PORT_DN_OFS  = 3;
  localparam int unsigned ACK_EDGE_BIT = 3;
  localparam int unsigned ACK_OVF_BIT  = 2;

  typedef struct packed {
    logic [2:0] spare;
    logic       dn_en;
    logic       up_en;
    logic       irq_en;
    logic       ovf_en;
    logic       det_en;
  } ctrl_t;

  typedef struct packed {
    logic [2:0] spare;
    logic       dn_seen;
    logic       up_seen;
    logic       irq_on;
    logic       ovf_pend;
    logic       ev_pend;
  } stat_t;
endpackage

// File: rtl/chg_sync.sv
`timescale 1ns/1ps
module chg_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign cur  = sync_q;
  assign prev = last_q;
endmodule

// File: rtl/chg_port_unit.sv
`timescale 1ns/1ps
module chg_port_unit
  import chg_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PORT_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        cur,
  input  logic [7:0]        prev,
  output logic [7:0]        up_mask,
  output logic [7:0]        dn_mask,
  output logic              up_hit,
  output logic              dn_hit
);
  localparam int unsigned BASE = PORT_BASE + PORT_IDX * PORT_STRIDE;
  localparam logic [ADDR_W-1:0] UP_ADDR = ADDR_W'(BASE + PORT_UP_OFS);
  localparam logic [ADDR_W-1:0] DN_ADDR = ADDR_W'(BASE + PORT_DN_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_mask <= '0;
      dn_mask <= '0;
    end else if (wr) begin
      if (addr == UP_ADDR) up_mask <= wdata;
      if (addr == DN_ADDR) dn_mask <= wdata;
    end
  end

  assign up_hit = |(cur & ~prev & up_mask);
  assign dn_hit = |(~cur & prev & dn_mask);
endmodule

// File: rtl/chg_event_ctrl.sv
`timescale 1ns/1ps
module chg_event_ctrl
  import chg_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              up_any,
  input  logic              dn_any,
  output logic [7:0]        ctrl_byte,
  output logic [7:0]        stat_byte,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] ACK_ADDR  = ADDR_W'(OFS_CLEAR);

  ctrl_t ctrl_q;
  logic  ev_q, ovf_q, up_q, dn_q;
  logic  wr_ctrl, wr_ack, ack_ev, ack_ovf;
  logic  up_ev, dn_ev, any_ev, ovf_set;
  stat_t stat;

  assign wr_ctrl = wr && (addr == CTRL_ADDR);
  assign wr_ack  = wr && (addr == ACK_ADDR);
  assign ack_ev  = wr_ack && wdata[ACK_EDGE_BIT];
  assign ack_ovf = wr_ack && wdata[ACK_OVF_BIT];

  assign up_ev   = up_any && ctrl_q.det_en && ctrl_q.up_en;
  assign dn_ev   = dn_any && ctrl_q.det_en && ctrl_q.dn_en;
  assign any_ev  = up_ev || dn_ev;
  // a merged event counts only if the earlier one is not being acknowledged now
  assign ovf_set = any_ev && ev_q && ctrl_q.ovf_en && !ack_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ev_q   <= 1'b0;
      ovf_q  <= 1'b0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'({3'b000, wdata[4:0]});
      ev_q  <= (ev_q  && !ack_ev)  || any_ev;
      up_q  <= (up_q  && !ack_ev)  || up_ev;
      dn_q  <= (dn_q  && !ack_ev)  || dn_ev;
      ovf_q <= (ovf_q && !ack_ovf) || ovf_set;
    end
  end

  assign irq = ctrl_q.irq_en && (ev_q || ovf_q);

  always_comb begin
    stat          = '0;
    stat.ev_pend  = ev_q;
    stat.ovf_pend = ovf_q;
    stat.irq_on   = irq;
    stat.up_seen  = up_q;
    stat.dn_seen  = dn_q;
  end

  assign stat_byte = stat;
  assign ctrl_byte = ctrl_q;

  // wdata[7:5] only reach the reserved control bits, which read back zero
  logic unused_hi;
  assign unused_hi = ^wdata[7:5];
endmodule

// File: rtl/chg_irq_top.sv
`timescale 1ns/1ps
module chg_irq_top
  import chg_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic [NUM_PORTS*8-1:0] din,
  output logic                   irq
);
  localparam int DIN_W = NUM_PORTS * 8;

  logic [DIN_W-1:0]     cur_all, prev_all;
  logic [7:0]           up_mask [NUM_PORTS];
  logic [7:0]           dn_mask [NUM_PORTS];
  logic [NUM_PORTS-1:0] up_hits, dn_hits;
  logic [7:0]           ctrl_q, status_q;

  chg_sync #(.W(DIN_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (din),
    .cur  (cur_all),
    .prev (prev_all)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    chg_port_unit #(.ADDR_W(ADDR_W), .PORT_IDX(p)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .cur    (cur_all[p*8 +: 8]),
      .prev   (prev_all[p*8 +: 8]),
      .up_mask(up_mask[p]),
      .dn_mask(dn_mask[p]),
      .up_hit (up_hits[p]),
      .dn_hit (dn_hits[p])
    );
  end

  chg_event_ctrl #(.ADDR_W(ADDR_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .up_any   (|up_hits),
    .dn_any   (|dn_hits),
    .ctrl_byte(ctrl_q),
    .stat_byte(status_q),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_STATUS)) bus_rdata = status_q;
    if (bus_addr == ADDR_W'(OFS_CTRL))   bus_rdata = ctrl_q;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(PORT_BASE + p * PORT_STRIDE + PORT_UP_OFS)) bus_rdata = up_mask[p];
      if (bus_addr == ADDR_W'(PORT_BASE + p * PORT_STRIDE + PORT_DN_OFS)) bus_rdata = dn_mask[p];
    end
  end
endmodule

// File: rtl/chg_irq_checker.sv
`timescale 1ns/1ps
module chg_irq_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              irq,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        status_q
);
  p_ctrl_zero_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(3) && bus_wdata == 8'h00) |=> !irq);

  p_event_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !(bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[3])) |=> status_q[0]);

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[3] && bus_wdata[2]) |=> !status_q[1]);

  p_ovf_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[1]) |-> $past(status_q[0]));

  p_no_event_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !status_q[0]) |=> !status_q[0]);
endmodule

bind chg_irq_top chg_irq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .ctrl_q   (ctrl_q),
  .status_q (status_q)
);

// File: tb/chg_irq_top_tb.sv
`timescale 1ns/1ps
module chg_irq_top_tb;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP*8-1:0] din = '0;
  logic          irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chg_irq_top #(.NUM_PORTS(NP), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic expect_irq(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic pin(input int idx, input logic v);
    @(negedge clk);
    din[idx] = v;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic quiet();
    wr(8'h03, 8'h00);
    @(negedge clk);
    din = '0;
    settle(4);
    wr(8'h01, 8'h0C);
  endtask

  task automatic t_reset();
    expect_reg("R1 status", 8'h02, 8'h00);
    expect_reg("R1 ctrl", 8'h03, 8'h00);
    expect_reg("R1 port0 up mask", 8'h42, 8'h00);
    expect_reg("R1 port2 dn mask", 8'h63, 8'h00);
    expect_irq("R1 irq", 1'b0);
  endtask

  task automatic t_masks();
    wr(8'h42, 8'h81);
    wr(8'h43, 8'h18);
    wr(8'h62, 8'h0F);
    wr(8'h63, 8'hF0);
    expect_reg("R2 port0 up", 8'h42, 8'h81);
    expect_reg("R2 port0 dn", 8'h43, 8'h18);
    expect_reg("R2 port2 up", 8'h62, 8'h0F);
    expect_reg("R2 port2 dn", 8'h63, 8'hF0);
    expect_reg("R2 port1 up untouched", 8'h52, 8'h00);
    expect_reg("R2 port1 dn untouched", 8'h53, 8'h00);
  endtask

  task automatic t_rise();
    quiet();
    wr(8'h03, 8'h1D);
    pin(0, 1'b1);
    settle(2);
    expect_reg("R3 not before third edge", 8'h02, 8'h00);
    settle(1);
    expect_reg("R3 rise status", 8'h02, 8'h0D);
    expect_irq("R9 irq with pending edge", 1'b1);
    wr(8'h01, 8'h08);
    expect_reg("R8 edge cleared", 8'h02, 8'h00);
    expect_irq("R9 irq low after clear", 1'b0);
  endtask

  task automatic t_fall();
    quiet();
    wr(8'h03, 8'h1D);
    pin(20, 1'b1);
    settle(4);
    expect_reg("R5 up edge masked on port2", 8'h02, 8'h00);
    pin(20, 1'b0);
    settle(3);
    expect_reg("R4 fall status port2", 8'h02, 8'h15);
  endtask

  task automatic t_masked();
    quiet();
    wr(8'h03, 8'h1D);
    pin(1, 1'b1);
    settle(4);
    expect_reg("R5 channel mask clear", 8'h02, 8'h00);
    wr(8'h03, 8'h15);
    pin(0, 1'b1);
    settle(4);
    expect_reg("R5 direction disabled", 8'h02, 8'h00);
  endtask

  task automatic t_det_off();
    quiet();
    wr(8'h03, 8'h1C);
    pin(0, 1'b1);
    settle(4);
    expect_reg("R6 master enable off", 8'h02, 8'h00);
    expect_irq("R6 irq", 1'b0);
  endtask

  task automatic t_overflow();
    quiet();
    wr(8'h03, 8'h1F);
    pin(0, 1'b1);
    settle(3);
    expect_reg("R7 first edge", 8'h02, 8'h0D);
    pin(3, 1'b1);
    settle(4);
    expect_reg("R7 masked edge no overflow", 8'h02, 8'h0D);
    pin(3, 1'b0);
    settle(3);
    expect_reg("R7 overflow set", 8'h02, 8'h1F);
    wr(8'h01, 8'h00);
    expect_reg("R8 zero write no effect", 8'h02, 8'h1F);
    wr(8'h01, 8'h04);
    expect_reg("R8 overflow cleared only", 8'h02, 8'h1D);
    wr(8'h01, 8'h08);
    expect_reg("R8 all cleared", 8'h02, 8'h00);
    expect_irq("R9 irq after full clear", 1'b0);
    wr(8'h03, 8'h1D);
    pin(7, 1'b1);
    settle(4);
    expect_reg("R7 edge without ovf enable", 8'h02, 8'h0D);
    pin(3, 1'b1);
    settle(4);
    pin(3, 1'b0);
    settle(4);
    expect_reg("R7 no overflow when disabled", 8'h02, 8'h1D);
  endtask

  task automatic t_irq_gate();
    quiet();
    wr(8'h03, 8'h19);
    pin(0, 1'b1);
    settle(3);
    expect_reg("R9 pending without irq enable", 8'h02, 8'h09);
    expect_irq("R9 irq gated", 1'b0);
    wr(8'h03, 8'h1D);
    expect_irq("R9 irq follows enable", 1'b1);
    expect_reg("R9 status irq bit", 8'h02, 8'h0D);
    wr(8'h03, 8'h00);
    expect_irq("R10 irq low after zero ctrl", 1'b0);
    expect_reg("R10 flags kept", 8'h02, 8'h09);
    pin(7, 1'b1);
    settle(4);
    expect_reg("R10 no new events", 8'h02, 8'h09);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_rise();
    t_fall();
    t_masked();
    t_det_off();
    t_overflow();
    t_irq_gate();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule